// File: doc/BRIEF.md
# I2C Interrupt Status and Enable Bank

This block keeps the event flags of an I2C controller and turns them into one interrupt line. The protocol engine and the FIFO logic (outside this block) emit one-cycle event pulses. Each pulse sets a sticky status bit, which stays set until software writes a 1 to it.

The enable mask is never written directly. One register address sets mask bits and a second address clears them, so software can change one source without a read-modify-write. Reading either address returns the current mask. Two read views of the status exist. The raw view shows every latched event whatever the mask holds, plus a live bus-busy flag that software cannot clear. The masked view shows only the enabled events. The interrupt output is high whenever any enabled event is latched.

Software reaches the bank through a 16-bit register port with one enable per byte lane, so 8-bit and 16-bit accesses both work. Reads have no side effects.

Top module: `i2c_irq_bank`

## Requirements
- R1: After reset, all status bits, all enable bits and the bus-busy flag are 0, every register reads 0 and `irq` is low.
- R2: A 1 on `evt_pulse[i]` sets status bit i at the next clock edge, and the bit stays set while no clear is written. Bit positions: 0 no-acknowledge, 1 arbitration lost, 2 transfer complete, 3 receive ready, 4 transmit ready, 5 receive draining, 6 transmit draining.
- R3: A write to address 1 (status) clears every status bit whose write-data bit is 1 and leaves bits written 0 unchanged. Writing 0xFFFF clears all bits.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R5: A write changes only the byte lanes whose `reg_be` bit is 1 (`reg_be[0]` covers bits 7:0, `reg_be[1]` covers bits 15:8). A write of 0xFFFF to the status or enable-set address with only `reg_be[1]` set leaves the event bits and the mask unchanged.
- R6: A write to address 2 (enable set) sets each mask bit whose write-data bit is 1. Reading address 2 or address 3 returns the mask in bits 6:0, with the upper bits 0.
- R7: A write to address 3 (enable clear) clears each mask bit whose write-data bit is 1.
- R8: Reading address 0 (raw view) returns all latched status bits whatever the mask holds, with the bus-busy flag in bit 15. Writes to address 0 have no effect.
- R9: Reading address 1 returns status AND mask in bits 6:0. Bit 15 and the other upper bits read 0.
- R10: `irq` is high exactly when status AND mask is nonzero.
- R11: The bus-busy flag is set one cycle after `start_det` and cleared one cycle after `stop_det`. When both arrive in the same cycle, the flag is set. No register write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 raw, 1 status, 2 enable set, 3 enable clear |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_be | input | 2 | Byte-lane enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 7 | One-cycle event pulses from the protocol and FIFO logic |
| start_det | input | 1 | START condition detected on the bus |
| stop_det | input | 1 | STOP condition detected on the bus |
| irq | output | 1 | Interrupt request |

## Verification
Every piece of internal state in this block is visible at the ports within one cycle of the edge that changes it. A lost or stuck status bit appears in the raw view at the next read. A wrong mask bit appears in the enable readback and also changes `irq`. A bad busy flag appears in bit 15 of the raw view. The bench therefore reads a register right after each operation. Those reads expose a clear that spills across byte lanes, an event that loses to a clear in the same cycle, a leak between the raw and masked views, and a busy flag that a write can reach.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      ADR_RAW    = 2'd0,
      ADR_STATUS = 2'd1,
      ADR_EN_SET = 2'd2,
      ADR_EN_CLR = 2'd3
   } reg_adr_e;
endpackage

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
   parameter int NUM_EVT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] set_i,
   input  logic [NUM_EVT-1:0] clr_i,
   output logic [NUM_EVT-1:0] q_o
);
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_o[i] <= 1'b0;
         end else if (set_i[i]) begin
            q_o[i] <= 1'b1;   // event has priority over clear
         end else if (clr_i[i]) begin
            q_o[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/i2c_irq_mask.sv
module i2c_irq_mask #(
   parameter int NUM_EVT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] set_i,
   input  logic [NUM_EVT-1:0] clr_i,
   output logic [NUM_EVT-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else begin
         q_o <= (q_o | set_i) & ~clr_i;
      end
   end
endmodule

// File: rtl/i2c_irq_busy.sv
module i2c_irq_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   output logic busy_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
      end else if (start_i) begin
         busy_o <= 1'b1;
      end else if (stop_i) begin
         busy_o <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank
   import i2c_irq_pkg::*;
#(
   parameter int NUM_EVT  = 7,
   parameter int REG_W    = 16,
   parameter int BUSY_POS = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [REG_W/8-1:0] reg_be,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic               start_det,
   input  logic               stop_det,
   output logic               irq
);
   localparam int BE_W  = REG_W / 8;
   localparam int PAD_W = REG_W - NUM_EVT;

   if (REG_W % 8 != 0 || REG_W < 8) begin : g_bad_width
      $error("REG_W must be a nonzero multiple of 8");
   end
   if (NUM_EVT < 1 || NUM_EVT > BUSY_POS) begin : g_bad_evt
      $error("NUM_EVT must lie below BUSY_POS");
   end
   if (BUSY_POS >= REG_W) begin : g_bad_busy
      $error("BUSY_POS must fit in the register");
   end

   logic [REG_W-1:0]   lane_mask;
   logic [REG_W-1:0]   wbits;
   logic [NUM_EVT-1:0] stat_q;
   logic [NUM_EVT-1:0] en_q;
   logic               busy_q;
   logic [NUM_EVT-1:0] stat_clr;
   logic [NUM_EVT-1:0] en_set;
   logic [NUM_EVT-1:0] en_clr;
   logic [NUM_EVT-1:0] masked;
   logic               unused_hi;

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{reg_be[b]}};
   end

   assign wbits     = reg_wdata & lane_mask;
   assign unused_hi = ^wbits[REG_W-1:NUM_EVT];

   always_comb begin
      stat_clr = '0;
      en_set   = '0;
      en_clr   = '0;
      if (reg_wr) begin
         unique case (reg_adr_e'(reg_addr))
            ADR_STATUS: stat_clr = wbits[NUM_EVT-1:0];
            ADR_EN_SET: en_set   = wbits[NUM_EVT-1:0];
            ADR_EN_CLR: en_clr   = wbits[NUM_EVT-1:0];
            default:    ;
         endcase
      end
   end

   i2c_irq_status #(.NUM_EVT(NUM_EVT)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_pulse),
      .clr_i (stat_clr),
      .q_o   (stat_q)
   );

   i2c_irq_mask #(.NUM_EVT(NUM_EVT)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (en_set),
      .clr_i (en_clr),
      .q_o   (en_q)
   );

   i2c_irq_busy u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_det),
      .stop_i  (stop_det),
      .busy_o  (busy_q)
   );

   assign masked = stat_q & en_q;
   assign irq    = |masked;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_adr_e'(reg_addr))
         ADR_RAW: begin
            reg_rdata           = {{PAD_W{1'b0}}, stat_q};
            reg_rdata[BUSY_POS] = busy_q;
         end
         ADR_STATUS: reg_rdata = {{PAD_W{1'b0}}, masked};
         default:    reg_rdata = {{PAD_W{1'b0}}, en_q};
      endcase
   end
endmodule

// File: rtl/i2c_irq_bank_chk.sv
module i2c_irq_bank_chk #(
   parameter int NUM_EVT  = 7,
   parameter int REG_W    = 16,
   parameter int BUSY_POS = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         reg_addr,
   input logic               reg_wr,
   input logic [REG_W/8-1:0] reg_be,
   input logic [REG_W-1:0]   reg_wdata,
   input logic [REG_W-1:0]   reg_rdata,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic               start_det,
   input logic               stop_det,
   input logic [NUM_EVT-1:0] stat_q,
   input logic [NUM_EVT-1:0] en_q,
   input logic               busy_q,
   input logic               irq
);
   // R2: a pulsed event is latched on the next edge
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

   // R2: without events or writes, the status holds its value
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && evt_pulse == '0) |=> $stable(stat_q));

   // R3: a full-lane clear write with no event empties the written bits
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1 && reg_be[0] && evt_pulse == '0)
      |=> ((stat_q & $past(reg_wdata[NUM_EVT-1:0])) == '0));

   // R6
   a_r6_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2 && reg_be[0])
      |=> ((en_q & $past(reg_wdata[NUM_EVT-1:0])) == $past(reg_wdata[NUM_EVT-1:0])));

   // R7
   a_r7_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3 && reg_be[0])
      |=> ((en_q & $past(reg_wdata[NUM_EVT-1:0])) == '0));

   // R8: the raw view carries the live busy flag
   a_r8_raw_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> (reg_rdata[BUSY_POS] == busy_q));

   // R10
   a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_q != '0 && en_q != '0));

   // R11
   a_r11_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> busy_q);
   a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> !busy_q);
endmodule

bind i2c_irq_bank i2c_irq_bank_chk #(
   .NUM_EVT(NUM_EVT), .REG_W(REG_W), .BUSY_POS(BUSY_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_be    (reg_be),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .evt_pulse (evt_pulse),
   .start_det (start_det),
   .stop_det  (stop_det),
   .stat_q    (stat_q),
   .en_q      (en_q),
   .busy_q    (busy_q),
   .irq       (irq)
);

// File: tb/i2c_irq_bank_bench.sv
`timescale 1ns/1ps
module i2c_irq_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_be = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [6:0]  evt_pulse = '0;
   logic        start_det = 1'b0;
   logic        stop_det = 1'b0;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2c_irq_bank u_i2c_irq_bank (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_pulse(evt_pulse), .start_det(start_det), .stop_det(stop_det),
      .irq(irq)
   );

   typedef struct packed {
      logic [6:0]  evt;
      logic [1:0]  addr;
      logic        wr;
      logic [1:0]  be;
      logic [15:0] wdata;
      logic [1:0]  caddr;
      logic [15:0] exp;
      logic        eirq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      // R2: no-ack event latched
      '{7'h01, 2'd0, 1'b0, 2'd0, 16'h0000, 2'd0, 16'h0001, 1'b0, 4'd2},
      // R8: raw shows events with mask empty
      '{7'h48, 2'd0, 1'b0, 2'd0, 16'h0000, 2'd0, 16'h0049, 1'b0, 4'd8},
      // R6: enable set of bits 0 and 3
      '{7'h00, 2'd2, 1'b1, 2'd3, 16'h0009, 2'd2, 16'h0009, 1'b1, 4'd6},
      // R9: masked view
      '{7'h00, 2'd0, 1'b0, 2'd0, 16'h0000, 2'd1, 16'h0009, 1'b1, 4'd9},
      // R3: clear bit 0 only
      '{7'h00, 2'd1, 1'b1, 2'd3, 16'h0001, 2'd0, 16'h0048, 1'b1, 4'd3},
      // R7: clear enable bit 3, R10 irq drops
      '{7'h00, 2'd3, 1'b1, 2'd3, 16'h0008, 2'd2, 16'h0001, 1'b0, 4'd7},
      // R5: high lane only, no clear
      '{7'h00, 2'd1, 1'b1, 2'd2, 16'hFFFF, 2'd0, 16'h0048, 1'b0, 4'd5},
      // R4: event beats clear in same cycle
      '{7'h08, 2'd1, 1'b1, 2'd3, 16'h0008, 2'd0, 16'h0048, 1'b0, 4'd4},
      // R8: write to raw ignored
      '{7'h00, 2'd0, 1'b1, 2'd3, 16'hFFFF, 2'd0, 16'h0048, 1'b0, 4'd8},
      // R10: enabled event raises irq
      '{7'h01, 2'd0, 1'b0, 2'd0, 16'h0000, 2'd1, 16'h0001, 1'b1, 4'd10},
      // R3: 0xFFFF clears all
      '{7'h00, 2'd1, 1'b1, 2'd3, 16'hFFFF, 2'd0, 16'h0000, 1'b0, 4'd3},
      // R5: enable set on high lane only
      '{7'h00, 2'd2, 1'b1, 2'd2, 16'hFFFF, 2'd3, 16'h0001, 1'b0, 4'd5},
      // R6: only implemented mask bits
      '{7'h00, 2'd2, 1'b1, 2'd1, 16'h00FF, 2'd2, 16'h007F, 1'b0, 4'd6}
   };

   task automatic check(input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic read_chk(input string tag, input logic [1:0] a,
                           input logic [15:0] exp, input logic eirq);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
      check(tag, {15'd0, irq}, {15'd0, eirq});
   endtask

   task automatic pulse_bus(input logic st, input logic sp);
      @(negedge clk);
      start_det = st;
      stop_det  = sp;
      @(negedge clk);
      start_det = 1'b0;
      stop_det  = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      read_chk("R1", 2'd0, 16'h0000, 1'b0);
      read_chk("R1", 2'd2, 16'h0000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R1", 2'd1, 16'h0000, 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         evt_pulse = TBL[i].evt;
         reg_addr  = TBL[i].addr;
         reg_wr    = TBL[i].wr;
         reg_be    = TBL[i].be;
         reg_wdata = TBL[i].wdata;
         @(negedge clk);
         evt_pulse = '0;
         reg_wr    = 1'b0;
         reg_addr  = TBL[i].caddr;
         #1;
         total++;
         if (reg_rdata !== TBL[i].exp) begin
            bad++;
            $display("FAIL R%0d vec %0d rdata: actual=%h expected=%h",
                     TBL[i].req, i, reg_rdata, TBL[i].exp);
         end
         total++;
         if (irq !== TBL[i].eirq) begin
            bad++;
            $display("FAIL R%0d vec %0d irq: actual=%b expected=%b",
                     TBL[i].req, i, irq, TBL[i].eirq);
         end
      end

      // R11: START sets busy, visible in raw view only (R9)
      pulse_bus(1'b1, 1'b0);
      read_chk("R11", 2'd0, 16'h8000, 1'b0);
      read_chk("R9", 2'd1, 16'h0000, 1'b0);
      // R11: software cannot clear busy
      @(negedge clk);
      reg_addr = 2'd1; reg_wr = 1'b1; reg_be = 2'd3; reg_wdata = 16'hFFFF;
      @(negedge clk);
      reg_wr = 1'b0;
      read_chk("R11", 2'd0, 16'h8000, 1'b0);
      pulse_bus(1'b0, 1'b1);
      read_chk("R11", 2'd0, 16'h0000, 1'b0);
      pulse_bus(1'b1, 1'b1);
      read_chk("R11", 2'd0, 16'h8000, 1'b0);
      pulse_bus(1'b0, 1'b1);
      read_chk("R11", 2'd0, 16'h0000, 1'b0);

      // R2/R10: all events, all enabled (mask is 0x7F)
      @(negedge clk);
      evt_pulse = 7'h7F;
      @(negedge clk);
      evt_pulse = '0;
      read_chk("R10", 2'd1, 16'h007F, 1'b1);

      // R1: reset in mid-run clears everything
      pulse_bus(1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      read_chk("R1", 2'd0, 16'h0000, 1'b0);
      read_chk("R1", 2'd3, 16'h0000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R1", 2'd1, 16'h0000, 1'b0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule